// File: doc/BRIEF.md
# Backoff Datapath Built-In Self-Test

This block contains the random-backoff datapath of an Ethernet MAC together with a small self-test controller for it. The datapath has a pseudo-random LFSR, a backoff timeout counter, a slot-time counter, a collision counter with its own step divider, and a mask shift register that fills with ones. A one-cycle `start` pulse clears every element on the same clock edge. The elements then step together on a common enable until the timeout counter wraps. The controller then spends one cycle judging the final register contents and reports the result on `pass`, marked by a one-cycle `done` pulse.

All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake and no back-pressure. `busy` is high from the cycle after an accepted start until the cycle `done` rises. A start request made while `busy` is high is dropped.

Top module: `bko_bist_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done` and `pass` are all 0.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle for exactly 2^TMO_W + 1 cycles. `done` is high in the first cycle after that, with `busy` low.
- R3: `done` stays high for one cycle only.
- R4: In a fault-free run, `pass` is 1 at `done`. This requires all of the following at the stop point: the timeout counter has wrapped to zero; the slot counter (TMO_W+1 bits) reads exactly 2^TMO_W, so only its MSB is set; the collision counter (COLL_W bits, one step per 2^(TMO_W-COLL_W) enables) and its divider are zero; the mask register is all ones; the LFSR holds its expected end state.
- R5: The LFSR shifts toward its MSB. Its new LSB is the XOR of the bits selected by LFSR_TAPS (default bits 29, 5, 3 and 0). It starts from LFSR_SEED (default: only bit 29 set). Its expected end state is the state reached 2^TMO_W steps after the seed.
- R6: On an enabled cycle where the low MASK_W LFSR bits are all ones but the mask register is not yet all ones, a sticky error is set. That run then reports `pass` = 0.
- R7: `pass` changes only when `done` rises or when a start is accepted. An accepted start clears it to 0 on the next cycle, and it then holds until the following `done`.
- R8: `start` has no effect while `busy` is high. Each accepted start produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the self-test |
| busy | output | 1 | Self-test in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last completed run |

## Verification
The bench builds three instances.

- The first uses the default widths: a 10-bit timeout counter, so 1025 busy cycles per run.
- The second uses a 6-bit timeout counter, a 2-bit collision counter and a 4-bit mask. Its short 65-cycle runs make repeated starts and the clearing of `pass` cheap to exercise.
- The third uses the same small widths but seeds the LFSR with 1. Its low four bits reach all ones one step before the mask is full, so the sticky mask error and a failing verdict become reachable.

// File: rtl/bko_pkg.sv
package bko_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2
  } bist_state_e;

  // Elaboration-time model of the LFSR: state after a number of steps.
  function automatic logic [63:0] lfsr_advance(input logic [63:0] seed,
                                               input logic [63:0] taps,
                                               input int          width,
                                               input int          steps);
    logic [63:0] wmask;
    logic [63:0] s;
    logic        fb;
    wmask = (64'd1 << width) - 64'd1;
    s     = seed & wmask;
    for (int i = 0; i < steps; i++) begin
      fb = ^(s & taps & wmask);
      s  = ((s << 1) | {63'd0, fb}) & wmask;
    end
    return s;
  endfunction

endpackage

// File: rtl/bko_counter.sv
module bko_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/bko_lfsr.sv
module bko_lfsr #(
  parameter int              W    = 30,
  parameter logic [W-1:0]    TAPS = 30'h2000_0029,
  parameter logic [W-1:0]    SEED = {1'b1, {(W-1){1'b0}}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= SEED;
    else if (clr) q <= SEED;
    else if (en)  q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/bko_mask_sr.sv
module bko_mask_sr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= {q[W-2:0], 1'b1};
  end
endmodule

// File: rtl/bko_bist_ctrl.sv
module bko_bist_ctrl
  import bko_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tmo_full,
  input  logic verdict,
  output logic clr,
  output logic en,
  output logic busy,
  output logic done,
  output logic pass
);
  bist_state_e state_q, state_d;

  assign clr  = (state_q == ST_IDLE) && start;
  assign en   = (state_q == ST_RUN);
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_RUN;
      ST_RUN:   if (tmo_full) state_d = ST_CHECK;
      ST_CHECK: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_q == ST_CHECK);
      if (clr)                        pass <= 1'b0;
      else if (state_q == ST_CHECK)   pass <= verdict;
    end
  end
endmodule

// File: rtl/bko_bist_top.sv
module bko_bist_top
  import bko_pkg::*;
#(
  parameter int                 LFSR_W    = 30,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = 30'h2000_0029,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = {1'b1, {(LFSR_W-1){1'b0}}},
  parameter int                 TMO_W     = 10,
  parameter int                 COLL_W    = 4,
  parameter int                 MASK_W    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic pass
);
  localparam int SLOT_W = TMO_W + 1;
  localparam int DIV_W  = TMO_W - COLL_W;
  localparam int RUN_LEN = 2 ** TMO_W;
  localparam logic [SLOT_W-1:0] SLOT_END = {1'b1, {TMO_W{1'b0}}};
  localparam logic [LFSR_W-1:0] LFSR_END =
    LFSR_W'(lfsr_advance(64'(LFSR_SEED), 64'(LFSR_TAPS), LFSR_W, RUN_LEN));

  logic              clr, en;
  logic [LFSR_W-1:0] lfsr_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [SLOT_W-1:0] slot_q;
  logic [COLL_W-1:0] coll_q;
  logic [MASK_W-1:0] mask_q;
  logic              coll_inc, div_zero;
  logic              err_q, mask_full, lfsr_ones, verdict;

  bko_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .q(lfsr_q));

  bko_counter #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(en), .q(tmo_q));

  bko_counter #(.W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(en), .q(slot_q));

  generate
    if (DIV_W > 0) begin : g_div
      logic [DIV_W-1:0] div_q;
      bko_counter #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(en), .q(div_q));
      assign coll_inc = en && (&div_q);
      assign div_zero = (div_q == '0);
    end else begin : g_nodiv
      assign coll_inc = en;
      assign div_zero = 1'b1;
    end
  endgenerate

  bko_counter #(.W(COLL_W)) u_coll (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(coll_inc), .q(coll_q));

  bko_mask_sr #(.W(MASK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .q(mask_q));

  assign mask_full = &mask_q;
  assign lfsr_ones = &lfsr_q[MASK_W-1:0];

  // Sticky mask-check error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             err_q <= 1'b0;
    else if (clr)                           err_q <= 1'b0;
    else if (en && lfsr_ones && !mask_full) err_q <= 1'b1;
  end

  assign verdict = (tmo_q == '0) && (slot_q == SLOT_END) && (coll_q == '0)
                && div_zero && (lfsr_q == LFSR_END) && mask_full && !err_q;

  bko_bist_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_full(&tmo_q),
    .verdict(verdict), .clr(clr), .en(en), .busy(busy), .done(done),
    .pass(pass));
endmodule

// File: rtl/bko_bist_chk.sv
module bko_bist_chk #(
  parameter int TMO_W  = 10,
  parameter int COLL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [TMO_W-1:0]  tmo_q,
  input logic [TMO_W:0]    slot_q,
  input logic [COLL_W-1:0] coll_q
);
  localparam int BUSY_LEN = 2 ** TMO_W + 1;
  logic [TMO_W+1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (!busy) busy_cnt <= '0;
    else           busy_cnt <= busy_cnt + 1'b1;
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_cnt == (TMO_W+2)'(BUSY_LEN)));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass) |-> (done || busy));

  // R4
  slot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmo_q == '0 && slot_q != '0) |->
      (slot_q == {1'b1, {TMO_W{1'b0}}} && coll_q == '0));
endmodule

bind bko_bist_top bko_bist_chk #(.TMO_W(TMO_W), .COLL_W(COLL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass),
  .tmo_q(tmo_q), .slot_q(slot_q), .coll_q(coll_q));

// File: tb/sim_bko_bist_top.sv
`timescale 1ns/1ps
module sim_bko_bist_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] start = '0;
  logic [2:0] busy, done, pass;
  int cyc = 0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bko_bist_top u0 (.clk(clk), .rst_n(rst_n), .start(start[0]),
    .busy(busy[0]), .done(done[0]), .pass(pass[0]));
  bko_bist_top #(.TMO_W(6), .COLL_W(2), .MASK_W(4)) u1 (.clk(clk),
    .rst_n(rst_n), .start(start[1]), .busy(busy[1]), .done(done[1]),
    .pass(pass[1]));
  bko_bist_top #(.TMO_W(6), .COLL_W(2), .MASK_W(4), .LFSR_SEED(30'd1)) u2 (
    .clk(clk), .rst_n(rst_n), .start(start[2]), .busy(busy[2]),
    .done(done[2]), .pass(pass[2]));

  typedef struct { int inst; bit pass; int due; } exp_t;
  exp_t sb[$];
  bit exp_pass [3];
  int tmo_w [3] = '{10, 6, 6};

  task automatic check(input bit ok, input string req, input int act,
                       input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Independent model: run fails if LFSR low m bits are all ones before
  // the mask (m bits, one 1 per step) is full.
  function automatic bit pred_pass(input longint unsigned seed, input int t,
                                   input int m);
    longint unsigned s = seed;
    longint unsigned mk = (64'd1 << m) - 1;
    longint unsigned wm = (64'd1 << 30) - 1;
    longint unsigned taps = (64'd1 << 29) | (64'd1 << 5) | (64'd1 << 3) | 64'd1;
    bit bad = 0;
    for (int n = 0; n < (1 << t); n++) begin
      if (n < m && (s & mk) == mk) bad = 1;
      s = ((s << 1) | longint'(^(s & taps))) & wm;
    end
    return !bad;
  endfunction

  // Driver: pushes the expected completion, then drives start.
  task automatic launch(input int i, input int hold);
    exp_t e;
    @(negedge clk);
    e.inst = i;
    e.pass = exp_pass[i];
    e.due  = cyc + 2 + (1 << tmo_w[i]);
    sb.push_back(e);
    start[i] = 1'b1;
    repeat (hold) @(negedge clk);
    start[i] = 1'b0;
  endtask

  task automatic mon(input int i, input logic d, input logic p);
    exp_t e;
    if (d) begin
      if (sb.size() == 0) check(0, "R8 unexpected done", i, -1);
      else begin
        e = sb.pop_front();
        check(e.inst == i, "R8 done from instance", i, e.inst);
        check(cyc == e.due, "R2 done cycle", cyc, e.due);
        check(p == e.pass, e.pass ? "R4 R5 pass" : "R6 pass", p, e.pass);
      end
    end
  endtask

  // Monitor: compares results against the scoreboard as they appear.
  always @(negedge clk) if (rst_n) begin
    mon(0, done[0], pass[0]);
    mon(1, done[1], pass[1]);
    mon(2, done[2], pass[2]);
  end

  task automatic wait_done(input int i);
    do @(negedge clk); while (!done[i]);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_pass[0] = pred_pass(64'h2000_0000, 10, 10);
    exp_pass[1] = pred_pass(64'h2000_0000, 6, 4);
    exp_pass[2] = pred_pass(64'h1, 6, 4);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(busy[i] == 0, "R1 busy in reset", busy[i], 0);
      check(done[i] == 0, "R1 done in reset", done[i], 0);
      check(pass[i] == 0, "R1 pass in reset", pass[i], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && pass == 0, "R1 after reset",
          {busy, done, pass}, 0);

    // Default widths, single-cycle start
    launch(0, 1);
    check(busy[0] == 1, "R2 busy after start", busy[0], 1);
    check(pass[0] == 0, "R7 pass during run", pass[0], 0);
    wait_done(0);
    check(busy[0] == 0, "R2 busy at done", busy[0], 0);
    @(negedge clk);
    check(done[0] == 0, "R3 done width", done[0], 1'b0);
    repeat (5) @(negedge clk);
    check(pass[0] == exp_pass[0], "R7 pass held", pass[0], exp_pass[0]);

    // Start held high across the run: only one run results
    launch(0, 40);
    check(busy[0] == 1, "R8 busy while start held", busy[0], 1);
    wait_done(0);
    repeat (3) @(negedge clk);
    check(busy[0] == 0, "R8 no restart", busy[0], 0);

    // Small widths, back-to-back runs; pass cleared at start
    launch(1, 1);
    wait_done(1);
    @(negedge clk);
    check(pass[1] == exp_pass[1], "R7 pass before restart", pass[1],
          exp_pass[1]);
    launch(1, 1);
    check(pass[1] == 0, "R7 pass cleared by start", pass[1], 0);
    wait_done(1);

    // Seed 1: mask check trips
    launch(2, 1);
    wait_done(2);
    repeat (4) @(negedge clk);
    check(pass[2] == 0, "R6 pass stays low", pass[2], 0);
    launch(2, 1);
    wait_done(2);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R8 outstanding results", sb.size(), 0);
    check(busy == 0, "R2 all idle", busy, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule